// File: doc/BRIEF.md
# Per-Core Inter-Processor Interrupt Register Bank

This block keeps a small interrupt-request register set for every core of a multi-core cluster and drives one interrupt line per core. Each set holds a 32-bit pending word, a 32-bit mask of enabled bits, two write-only ports that raise or drop pending bits, and eight 32-bit message words. Cores use the message words to pass data to one another.

All traffic arrives on one 32-bit word-access register port. Each access carries the ID of the core that issued it, and that ID chooses which set the access reaches. A ring command lets any core mark a vector bit pending in another core's set. The command names the target core and a 5-bit vector. A target or requester ID with no matching core ends the access with a decode-error response and leaves every register unchanged. Each access gets a response one cycle later, and that response carries the read data and the status flags.

Top module: `ipi_bank`

## Requirements
- R1: After synchronous reset every pending, mask and message word is zero, every interrupt line is low and no response is signalled.
- R2: The requester ID picks the register set an access reaches. An ID of N or more answers with `rsp_err` = 1 and read data 0, and changes no register.
- R3: The pending word (offset 0x00) is read-only. A write to it changes nothing and answers with `rsp_ro_wr` = 1.
- R4: A write to offset 0x08 ORs the written value into the pending word. Reads of offsets 0x08 and 0x0C always return 0.
- R5: A write to offset 0x0C clears, in the pending word, every bit that is 1 in the written value.
- R6: An interrupt line goes high when a set operation leaves (pending AND mask) nonzero. It goes low when a clear write leaves pending equal to zero. In every other case it keeps its value, and writes to the mask at offset 0x04 do not move it.
- R7: Message words sit at offsets 0x20 to 0x3C, with word index (offset − 0x20) >> 2. A write stores the whole word, and a read returns it, in the requester's own set only.
- R8: A write to offset 0x40 is a ring command. Bits 25:16 give the target core and bits 4:0 give the vector. It acts as a set operation of (1 << vector) on the target's set, under the same line rule as R6. Every other bit is ignored.
- R9: A ring command whose target ID is N or more answers with `rsp_err` = 1 and changes no register and no interrupt line.
- R10: Only address bits 7:2 are decoded. Reads of unmapped offsets return 0, and writes to them change nothing.
- R11: Each access that is accepted while `req_valid` is high is answered by `rsp_valid` high in exactly the next cycle. Without an access, `rsp_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| req_core | input | CID_W (10) | ID of the core issuing the access |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Decode error: unknown requester or unknown ring target |
| rsp_ro_wr | output | 1 | A write was aimed at the read-only pending word |
| irq_out | output | N | One interrupt line per core |

## Verification
Register state, the interrupt lines and all response fields update on the clock edge that takes the access. So every result of an access shows up one cycle after it is presented. The bench drives each access on a falling edge and lets one rising edge take it. It then compares the response fields and all interrupt lines against its behavioural model at the following falling edge, before it presents the next access. Idle cycles are checked the same way, so that no line or response moves without a stimulus.

// File: rtl/ipi_pkg.sv
// Package: shared register selector type and address decode helper for the
// per-core interrupt register bank. Assumes word-aligned 32-bit accesses.
package ipi_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned ADDR_W   = 8;
    localparam int unsigned MB_WORDS = 8;
    localparam int unsigned MB_IDX_W = $clog2(MB_WORDS);

    typedef enum logic [2:0] {
        SEL_PEND,
        SEL_MASK,
        SEL_SET,
        SEL_CLR,
        SEL_MBOX,
        SEL_RING,
        SEL_NONE
    } ipi_sel_e;

    // Map a word offset (address bits 7:2) to a register selector.
    function automatic ipi_sel_e word_to_sel(input logic [5:0] word);
        ipi_sel_e s;
        case (word)
            6'h00:   s = SEL_PEND;
            6'h01:   s = SEL_MASK;
            6'h02:   s = SEL_SET;
            6'h03:   s = SEL_CLR;
            6'h10:   s = SEL_RING;
            default: s = (word[5:3] == 3'b001) ? SEL_MBOX : SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ipi_addr_decode.sv
// Address decoder: turns the low byte of the access address into a register
// selector and a message word index. Assumes bits 1:0 carry no meaning.
module ipi_addr_decode
    import ipi_pkg::*;
(
    input  logic [ADDR_W-1:0]   addr,
    output ipi_sel_e            sel,
    output logic [MB_IDX_W-1:0] mb_idx
);

    // Combinational decode of the word offset.
    always_comb begin
        sel    = word_to_sel(addr[7:2]);
        mb_idx = addr[2 +: MB_IDX_W];
    end

endmodule

// File: rtl/ipi_core_regs.sv
// One core's register set: pending word, mask, message words and its
// interrupt line. Assumes at most one of set/clear/mask/message write is
// active in a cycle; the parent guarantees this (one access per cycle).
module ipi_core_regs
    import ipi_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic [DATA_W-1:0]   set_val,
    input  logic                clr_en,
    input  logic                mask_we,
    input  logic                mb_we,
    input  logic [MB_IDX_W-1:0] mb_idx,
    input  logic [DATA_W-1:0]   wdata,
    input  ipi_sel_e            rd_sel,
    output logic [DATA_W-1:0]   rd_data,
    output logic                irq
);

    logic [DATA_W-1:0] pend_q;
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] mbox_q [MB_WORDS];
    logic [DATA_W-1:0] pend_set;
    logic [DATA_W-1:0] pend_clr;

    // Next pending values for the set and clear paths.
    always_comb begin
        pend_set = pend_q | set_val;
        pend_clr = pend_q & ~wdata;
    end

    // Pending word, mask and interrupt line update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            mask_q <= '0;
            irq    <= 1'b0;
        end else begin
            if (mask_we) begin
                mask_q <= wdata;
            end
            if (set_en) begin
                pend_q <= pend_set;
                if ((pend_set & mask_q) != '0) begin
                    irq <= 1'b1;
                end
            end else if (clr_en) begin
                pend_q <= pend_clr;
                if (pend_clr == '0) begin
                    irq <= 1'b0;
                end
            end
        end
    end

    // Message word storage, one register per word.
    for (genvar w = 0; w < MB_WORDS; w++) begin : g_mbox
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mbox_q[w] <= '0;
            end else if (mb_we && (mb_idx == MB_IDX_W'(w))) begin
                mbox_q[w] <= wdata;
            end
        end
    end

    // Read data for the selected register; write-only and unmapped read 0.
    always_comb begin
        case (rd_sel)
            SEL_PEND: rd_data = pend_q;
            SEL_MASK: rd_data = mask_q;
            SEL_MBOX: rd_data = mbox_q[mb_idx];
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/ipi_bank.sv
// Top: N per-core register sets behind one 32-bit register port. The
// requester ID steers each access; a ring command sets a vector bit in
// another core's set. Responses are registered, one cycle after the access.
// Assumes N >= 1 and N <= 2**CID_W.
module ipi_bank
    import ipi_pkg::*;
#(
    parameter int unsigned N     = 4,
    parameter int unsigned CID_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [7:0]        req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [CID_W-1:0]  req_core,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    output logic              rsp_ro_wr,
    output logic [N-1:0]      irq_out
);

    localparam int unsigned TGT_LSB = 16;
    localparam int unsigned VEC_W   = 5;

    ipi_sel_e              sel;
    logic [MB_IDX_W-1:0]   mb_idx;
    logic                  req_ok;
    logic                  tgt_ok;
    logic [CID_W-1:0]      tgt;
    logic                  wr_acc;
    logic                  rd_acc;
    logic [DATA_W-1:0]     set_val;
    logic [DATA_W-1:0]     rd_core [N];
    logic [DATA_W-1:0]     rd_pick;

    ipi_addr_decode u_dec (
        .addr   (req_addr),
        .sel    (sel),
        .mb_idx (mb_idx)
    );

    // Access qualification: known requester, known ring target.
    always_comb begin
        tgt     = req_wdata[TGT_LSB +: CID_W];
        req_ok  = 32'(req_core) < N;
        tgt_ok  = 32'(tgt) < N;
        wr_acc  = req_valid && req_write && req_ok;
        rd_acc  = req_valid && !req_write && req_ok;
        set_val = (sel == SEL_RING) ? (DATA_W'(1) << req_wdata[VEC_W-1:0]) : req_wdata;
    end

    // One register set per core with its own write strobes.
    for (genvar c = 0; c < N; c++) begin : g_core
        logic own;
        logic ring_hit;
        assign own      = wr_acc && (req_core == CID_W'(c));
        assign ring_hit = wr_acc && (sel == SEL_RING) && tgt_ok && (tgt == CID_W'(c));

        ipi_core_regs u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_en  ((own && (sel == SEL_SET)) || ring_hit),
            .set_val (set_val),
            .clr_en  (own && (sel == SEL_CLR)),
            .mask_we (own && (sel == SEL_MASK)),
            .mb_we   (own && (sel == SEL_MBOX)),
            .mb_idx  (mb_idx),
            .wdata   (req_wdata),
            .rd_sel  (sel),
            .rd_data (rd_core[c]),
            .irq     (irq_out[c])
        );
    end

    // Select the requester's read data.
    always_comb begin
        rd_pick = '0;
        for (int c = 0; c < N; c++) begin
            if (req_core == CID_W'(c)) begin
                rd_pick = rd_core[c];
            end
        end
    end

    // Registered response, one cycle after the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
            rsp_ro_wr <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= rd_acc ? rd_pick : '0;
            rsp_err   <= req_valid && (!req_ok || (req_write && (sel == SEL_RING) && !tgt_ok));
            rsp_ro_wr <= wr_acc && (sel == SEL_PEND);
        end
    end

endmodule

// File: rtl/ipi_bank_chk.sv
// Checker for ipi_bank: temporal properties on ports only. Bound to every
// instance of the top module below.
module ipi_bank_chk #(
    parameter int unsigned N     = 4,
    parameter int unsigned CID_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_write,
    input logic [7:0]       req_addr,
    input logic [31:0]      req_wdata,
    input logic [CID_W-1:0] req_core,
    input logic             rsp_valid,
    input logic [31:0]      rsp_rdata,
    input logic             rsp_err,
    input logic             rsp_ro_wr,
    input logic [N-1:0]     irq_out
);

    logic known_req;
    logic ring_bad;
    assign known_req = 32'(req_core) < N;
    assign ring_bad  = req_valid && req_write && known_req && (req_addr[7:2] == 6'h10)
                       && (32'(req_wdata[25:16]) >= N);

    // Reset leaves all lines low and no response.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (irq_out == '0) && !rsp_valid);

    // Unknown requester gets a decode error and no line moves.
    assert_bad_requester_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !known_req) |=> rsp_err && (rsp_rdata == '0) && $stable(irq_out));

    // Pending word write is flagged and moves no line.
    assert_pend_readonly_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && known_req && (req_addr[7:2] == 6'h00))
        |=> rsp_ro_wr && $stable(irq_out));

    // Set and clear ports read as zero.
    assert_wo_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && ((req_addr[7:2] == 6'h02) || (req_addr[7:2] == 6'h03)))
        |=> (rsp_rdata == '0));

    // A line can only rise after a write access.
    assert_irq_rise_needs_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_out & ~$past(irq_out)) != '0) |-> $past(req_valid && req_write));

    // Mask writes never move a line.
    assert_mask_keeps_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && (req_addr[7:2] == 6'h01)) |=> $stable(irq_out));

    // Ring command to unknown target: error, no line change.
    assert_ring_unknown_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ring_bad |=> rsp_err && $stable(irq_out));

    // Unmapped reads return zero.
    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && (req_addr[7:2] >= 6'h11)) |=> (rsp_rdata == '0));

    // Response follows each access by exactly one cycle.
    assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_rsp_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

endmodule

bind ipi_bank ipi_bank_chk #(.N(N), .CID_W(CID_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_core  (req_core),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err),
    .rsp_ro_wr (rsp_ro_wr),
    .irq_out   (irq_out)
);

// File: tb/ipi_bank_tb.sv
// Bench for ipi_bank: behavioural model of each core's registers, compared
// with the response and the interrupt lines after every clock.
module ipi_bank_tb;

    localparam int N     = 4;
    localparam int CID_W = 10;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             req_valid;
    logic             req_write;
    logic [7:0]       req_addr;
    logic [31:0]      req_wdata;
    logic [CID_W-1:0] req_core;
    logic             rsp_valid;
    logic [31:0]      rsp_rdata;
    logic             rsp_err;
    logic             rsp_ro_wr;
    logic [N-1:0]     irq_out;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done = 1'b0;

    // model state
    int unsigned m_pend [N];
    int unsigned m_mask [N];
    int unsigned m_mbox [N][8];
    bit [N-1:0]  m_irq;

    always #10 clk = ~clk;

    ipi_bank #(.N(N), .CID_W(CID_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_core  (req_core),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err),
        .rsp_ro_wr (rsp_ro_wr),
        .irq_out   (irq_out)
    );

    task automatic model_set(input int c, input int unsigned v);
        m_pend[c] = m_pend[c] | v;
        if ((m_pend[c] & m_mask[c]) != 0) m_irq[c] = 1'b1;
    endtask

    task automatic compare(input string tag, input bit ev, input int unsigned ed,
                           input bit ee, input bit er);
        total++;
        if (rsp_valid !== ev || rsp_rdata !== ed || rsp_err !== ee ||
            rsp_ro_wr !== er || irq_out !== m_irq) begin
            bad++;
            $display("FAIL %s: got v=%0b d=%08h e=%0b ro=%0b irq=%b exp v=%0b d=%08h e=%0b ro=%0b irq=%b",
                     tag, rsp_valid, rsp_rdata, rsp_err, rsp_ro_wr, irq_out,
                     ev, ed, ee, er, m_irq);
        end
    endtask

    // One access: drive at falling edge, model it, check one cycle later.
    task automatic acc(input string tag, input bit wr, input logic [7:0] a,
                       input int unsigned d, input int core);
        int unsigned ed;
        bit ee;
        bit er;
        int tg;
        ed = 0; ee = 0; er = 0;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        req_core = CID_W'(core);
        if (core >= N) begin
            ee = 1;
        end else begin
            case (a[7:2])
                6'h00: if (wr) er = 1; else ed = m_pend[core];
                6'h01: if (wr) m_mask[core] = d; else ed = m_mask[core];
                6'h02: if (wr) model_set(core, d);
                6'h03: if (wr) begin
                           m_pend[core] = m_pend[core] & ~d;
                           if (m_pend[core] == 0) m_irq[core] = 1'b0;
                       end
                6'h10: if (wr) begin
                           tg = int'((d >> 16) & 32'h3FF);
                           if (tg >= N) ee = 1;
                           else model_set(tg, 32'h1 << (d & 32'h1F));
                       end
                default: if (a[7:5] == 3'b001) begin
                             if (wr) m_mbox[core][a[4:2]] = d;
                             else ed = m_mbox[core][a[4:2]];
                         end
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        compare(tag, 1'b1, ed, ee, er);
    endtask

    task automatic idle(input string tag);
        @(posedge clk);
        @(negedge clk);
        compare(tag, 1'b0, 0, 0, 0);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog: got cycles=%0d exp below 20000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < N; c++) begin
            m_pend[c] = 0; m_mask[c] = 0;
            for (int w = 0; w < 8; w++) m_mbox[c][w] = 0;
        end
        m_irq = '0;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0; req_core = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset", 1'b0, 0, 0, 0);
        for (int c = 0; c < N; c++) begin
            acc("R1 pend zero", 0, 8'h00, 0, c);
            acc("R1 mask zero", 0, 8'h04, 0, c);
            acc("R1 mbox zero", 0, 8'h3C, 0, c);
        end

        // R4 set, R6 masked set keeps line low
        acc("R6 mask write", 1, 8'h04, 32'h0000_00F0, 0);
        acc("R4 set or", 1, 8'h08, 32'h0000_0003, 0);
        acc("R4 set or 2", 1, 8'h08, 32'h0000_0100, 0);
        acc("R4 pend read", 0, 8'h00, 0, 0);
        acc("R4 set reads zero", 0, 8'h08, 0, 0);
        acc("R4 clear reads zero", 0, 8'h0C, 0, 0);
        acc("R6 raise", 1, 8'h08, 32'h0000_0010, 0);
        // R5 clear, R6 hold while nonzero then drop
        acc("R5 clear part", 1, 8'h0C, 32'h0000_0013, 0);
        acc("R5 pend after clear", 0, 8'h00, 0, 0);
        acc("R6 mask zero keeps line", 1, 8'h04, 32'h0, 0);
        acc("R5 clear all", 1, 8'h0C, 32'hFFFF_FFFF, 0);
        acc("R6 mask restore", 1, 8'h04, 32'h0000_00F0, 0);
        acc("R6 set unmasked bit only", 1, 8'h08, 32'h0000_0001, 0);
        acc("R5 clear leaves zero", 1, 8'h0C, 32'h0000_0001, 0);

        // R3 read-only pending word
        acc("R3 set before ro", 1, 8'h08, 32'h0000_0020, 0);
        acc("R3 write pending", 1, 8'h00, 32'h0, 0);
        acc("R3 pend unchanged", 0, 8'h00, 0, 0);

        // R7 message words
        for (int w = 0; w < 8; w++)
            acc("R7 mbox write", 1, 8'(8'h20 + w * 4), 32'hA5A5_0000 + w, 1);
        for (int w = 0; w < 8; w++)
            acc("R7 mbox read", 0, 8'(8'h20 + w * 4), 0, 1);
        acc("R7 other core untouched", 0, 8'h20, 0, 2);

        // R8 ring command
        acc("R8 target mask", 1, 8'h04, 32'h8000_0000, 3);
        acc("R8 ring vec31", 1, 8'h40, 32'h0003_001F, 0);
        acc("R8 target pend", 0, 8'h00, 0, 3);
        acc("R8 ring junk bits", 1, 8'h40, 32'hFC02_FFE2, 1);
        acc("R8 junk target pend", 0, 8'h00, 0, 2);
        acc("R8 sender pend", 0, 8'h00, 0, 1);

        // R9 unknown ring target
        acc("R9 ring target 4", 1, 8'h40, 32'h0004_0001, 0);
        acc("R9 ring target max", 1, 8'h40, 32'h03FF_0005, 2);
        acc("R9 no change", 0, 8'h00, 0, 2);

        // R2 unknown requester
        acc("R2 bad requester write", 1, 8'h08, 32'hFFFF_FFFF, 5);
        acc("R2 bad requester read", 0, 8'h00, 0, 1023);
        acc("R2 bad requester ring", 1, 8'h40, 32'h0001_0002, 4);
        acc("R2 core1 isolated", 0, 8'h00, 0, 1);

        // R10 unmapped
        acc("R10 unmapped read", 0, 8'h10, 0, 0);
        acc("R10 unmapped read high", 0, 8'hFC, 0, 0);
        acc("R10 unmapped write", 1, 8'h44, 32'hFFFF_FFFF, 0);
        acc("R10 low bits ignored", 0, 8'h07, 0, 0);
        acc("R10 state kept", 0, 8'h00, 0, 0);

        // R11 no response without access
        idle("R11 idle");
        idle("R11 idle 2");

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule